// File: doc/BRIEF.md
# Interrupt Polling and Fault Dispatcher

This block sits in a readout controller and answers the interrupt line that all front-end cards on one branch share. When the line is high and the block is idle, it walks the branch from card 0 up to the last card. For each card that is still powered, it reads the card's status word over a simple request/response bus master port. The request stays up until the addressed card answers. The answer says whether the card acknowledged, and it carries the status word.

Each status word is sorted into a verdict. A hard fault sets a sticky power-off output for that card. A soft fault takes the card out of the readout-enable list. It also starts a write that masks the soft bits in the card's mask register. Every action emits a one-cycle notification that carries the card number, the raw word and an action code. After the last card, the block waits for a hold-off delay that software programs. It then rescans if the interrupt is still high, and otherwise goes back to idle.

Top module: `irq_fault_dispatcher`

## Requirements
- R1: After reset, power_off is all zeros, readout_en is all ones, and req_valid and notify_valid are low. With irq_in low the block issues no bus requests.
- R2: A scan reads register address 0x11 (req_write=0) of the cards in ascending order, one request at a time. Each request is held with a stable card, register and direction until a cycle with rsp_valid high.
- R3: A card whose power_off bit is set gets no request during a scan.
- R4: An acknowledged status word with any of bits 4 to 7 set (overcurrent, supply fault, regulator fault) sets that card's power_off bit. It notifies with action code 1 and no write is issued.
- R5: An acknowledged status word with any of bits 0 to 3 set (over-temperature, undervoltage, missing sampling clock) and none of bits 4 to 7 clears that card's readout_en bit. It notifies with action code 2, then writes register address 0x12 of that card with data equal to the word ANDed with 0x000F.
- R6: A word with both hard and soft bits gets only the R4 treatment: readout_en stays set and no mask write is issued.
- R7: A response with rsp_ack low counts as a hard fault. The card is powered off and notified with action code 1 and error word 0.
- R8: Bits 8 to 15 of the status word, and a zero word, cause no action, no notification and no write.
- R9: A notification is a one-cycle notify_valid pulse in the cycle after the response. It carries the card number, the raw status word and the action code.
- R10: The last card's request is completed at clock edge E. If irq_in is high after the hold-off, the next scan's first read request is visible holdoff_cyc+2 cycles after E. If irq_in is low at that point, the block returns to idle.
- R11: power_off bits never clear except by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 1 | Shared branch interrupt, level |
| holdoff_cyc | input | HOLD_W | Hold-off cycles between scans |
| req_valid | output | 1 | Bus request pending |
| req_write | output | 1 | 1 = register write, 0 = read |
| req_card | output | CARD_W | Card address of the request |
| req_reg | output | 5 | Register address of the request |
| req_wdata | output | 16 | Write data (mask bits) |
| rsp_valid | input | 1 | Response for the pending request |
| rsp_ack | input | 1 | Card acknowledged |
| rsp_rdata | input | 16 | Read data (status word) |
| power_off | output | NCARD | Per-card power-off command, sticky |
| readout_en | output | NCARD | Per-card readout-enable list |
| notify_valid | output | 1 | Notification strobe |
| notify_card | output | CARD_W | Card of the notification |
| notify_err | output | 16 | Raw status word |
| notify_act | output | 2 | 1 = powered off, 2 = removed and masked |

## Verification
Each status pattern is placed on a single card, with the other cards quiet. The patterns are soft only, hard only, hard with soft, a missing acknowledge, and bits outside both classes. These separate the two response tiers and show whether a hard fault overrides a soft one. They also show whether ignored bits leak into an action. A later scan with several cards already off tells apart skipping from reading. It also checks the last card index, which here carries a soft fault. Holding the interrupt high across two scans measures the exact gap between them, which exposes off-by-one errors in the hold-off count.

// File: rtl/fdisp_pkg.sv
package fdisp_pkg;

    parameter int unsigned ERR_W = 16;
    parameter int unsigned REG_W = 5;

    localparam logic [REG_W-1:0] STATUS_REG = 5'h11;
    localparam logic [REG_W-1:0] MASK_REG   = 5'h12;

    localparam logic [ERR_W-1:0] SOFT_BITS = 16'h000F;
    localparam logic [ERR_W-1:0] HARD_BITS = 16'h00F0;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_OFF  = 2'd1,
        ACT_DROP = 2'd2
    } act_e;

    typedef struct packed {
        act_e             act;
        logic [ERR_W-1:0] mask;
    } verdict_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_READ,
        S_MASK,
        S_HOLD
    } st_e;

    function automatic verdict_t judge(input logic acked, input logic [ERR_W-1:0] w);
        verdict_t v;
        v.mask = w & SOFT_BITS;
        if (!acked)                v.act = ACT_OFF;
        else if ((w & HARD_BITS) != '0) v.act = ACT_OFF;
        else if (v.mask != '0)     v.act = ACT_DROP;
        else                       v.act = ACT_NONE;
        return v;
    endfunction

endpackage

// File: rtl/fdisp_classify.sv
module fdisp_classify
    import fdisp_pkg::*;
(
    input  logic             acked,
    input  logic [ERR_W-1:0] word,
    output verdict_t         verdict
);

    always_comb verdict = judge(acked, word);

    always_comb begin
        if (!acked) a_r7_noack_is_hard : assert (verdict.act == ACT_OFF);
    end

endmodule

// File: rtl/fdisp_holdoff.sv
module fdisp_holdoff #(
    parameter int HOLD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [HOLD_W-1:0] load_val,
    output logic              expired
);

    logic [HOLD_W-1:0] cnt;
    logic              active;

    assign expired = active && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            active <= 1'b0;
        end else if (start) begin
            cnt    <= load_val;
            active <= 1'b1;
        end else if (expired) begin
            active <= 1'b0;
        end else if (active) begin
            cnt <= cnt - 1'b1;
        end
    end

    a_r10_expire_once : assert property (@(posedge clk) disable iff (rst)
        expired && !start |=> !expired);

endmodule

// File: rtl/fdisp_cardmap.sv
module fdisp_cardmap #(
    parameter int NCARD  = 13,
    parameter int CARD_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CARD_W-1:0] sel,
    input  logic              set_off,
    input  logic              clr_en,
    output logic [NCARD-1:0]  power_off,
    output logic [NCARD-1:0]  readout_en
);

    for (genvar i = 0; i < NCARD; i++) begin : g_card
        always_ff @(posedge clk) begin
            if (rst) begin
                power_off[i]  <= 1'b0;
                readout_en[i] <= 1'b1;
            end else if (sel == CARD_W'(i)) begin
                if (set_off) power_off[i]  <= 1'b1;
                if (clr_en)  readout_en[i] <= 1'b0;
            end
        end
    end

    a_r11_off_sticky : assert property (@(posedge clk) disable iff (rst)
        (power_off & $past(power_off)) == $past(power_off));

endmodule

// File: rtl/irq_fault_dispatcher.sv
module irq_fault_dispatcher
    import fdisp_pkg::*;
#(
    parameter  int NCARD  = 13,
    parameter  int HOLD_W = 16,
    localparam int CARD_W = (NCARD > 1) ? $clog2(NCARD) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              irq_in,
    input  logic [HOLD_W-1:0] holdoff_cyc,
    output logic              req_valid,
    output logic              req_write,
    output logic [CARD_W-1:0] req_card,
    output logic [4:0]        req_reg,
    output logic [15:0]       req_wdata,
    input  logic              rsp_valid,
    input  logic              rsp_ack,
    input  logic [15:0]       rsp_rdata,
    output logic [NCARD-1:0]  power_off,
    output logic [NCARD-1:0]  readout_en,
    output logic              notify_valid,
    output logic [CARD_W-1:0] notify_card,
    output logic [15:0]       notify_err,
    output logic [1:0]        notify_act
);

    st_e               st;
    logic [CARD_W-1:0] idx;
    logic [ERR_W-1:0]  mask_q;
    act_e              nact_q;
    verdict_t          verdict;
    logic              last, step_done, go_hold, ho_expired, rd_done;

    fdisp_classify u_cls (
        .acked   (rsp_ack),
        .word    (rsp_rdata),
        .verdict (verdict)
    );

    fdisp_holdoff #(.HOLD_W(HOLD_W)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .start    (go_hold),
        .load_val (holdoff_cyc),
        .expired  (ho_expired)
    );

    assign rd_done = (st == S_READ) && rsp_valid;

    fdisp_cardmap #(.NCARD(NCARD), .CARD_W(CARD_W)) u_map (
        .clk        (clk),
        .rst        (rst),
        .sel        (idx),
        .set_off    (rd_done && verdict.act == ACT_OFF),
        .clr_en     (rd_done && verdict.act == ACT_DROP),
        .power_off  (power_off),
        .readout_en (readout_en)
    );

    assign last = (idx == CARD_W'(NCARD - 1));

    always_comb begin
        step_done = 1'b0;
        case (st)
            S_CHECK: step_done = power_off[idx];
            S_READ:  step_done = rsp_valid && (verdict.act != ACT_DROP);
            S_MASK:  step_done = rsp_valid;
            default: step_done = 1'b0;
        endcase
    end
    assign go_hold = step_done && last;

    always_ff @(posedge clk) begin
        if (rst) begin
            st           <= S_IDLE;
            idx          <= '0;
            mask_q       <= '0;
            nact_q       <= ACT_NONE;
            notify_valid <= 1'b0;
            notify_card  <= '0;
            notify_err   <= '0;
        end else begin
            notify_valid <= 1'b0;
            if (rd_done && verdict.act != ACT_NONE) begin
                notify_valid <= 1'b1;
                notify_card  <= idx;
                notify_err   <= rsp_ack ? rsp_rdata : '0;
                nact_q       <= verdict.act;
            end
            if (step_done) begin
                if (last) st <= S_HOLD;
                else begin
                    idx <= idx + 1'b1;
                    st  <= S_CHECK;
                end
            end else begin
                case (st)
                    S_IDLE: if (irq_in) begin
                        idx <= '0;
                        st  <= S_CHECK;
                    end
                    S_CHECK: st <= S_READ;
                    S_READ: if (rsp_valid) begin
                        mask_q <= verdict.mask;
                        st     <= S_MASK;
                    end
                    S_HOLD: if (ho_expired) begin
                        idx <= '0;
                        st  <= irq_in ? S_CHECK : S_IDLE;
                    end
                    default: st <= st;
                endcase
            end
        end
    end

    assign notify_act = nact_q;
    assign req_valid  = (st == S_READ) || (st == S_MASK);
    assign req_write  = (st == S_MASK);
    assign req_card   = idx;
    assign req_reg    = (st == S_MASK) ? MASK_REG : STATUS_REG;
    assign req_wdata  = (st == S_MASK) ? mask_q : '0;

    a_r2_req_held : assert property (@(posedge clk) disable iff (rst)
        req_valid && !rsp_valid |=> req_valid && $stable(req_card) && $stable(req_write) && $stable(req_reg));

    a_r3_no_req_to_off_card : assert property (@(posedge clk) disable iff (rst)
        req_valid |-> !power_off[req_card]);

    a_r5_mask_payload : assert property (@(posedge clk) disable iff (rst)
        req_valid && req_write |-> ((req_wdata & ~SOFT_BITS) == '0) && (req_wdata != '0));

    a_r9_notify_after_rsp : assert property (@(posedge clk) disable iff (rst)
        notify_valid |-> $past(rsp_valid));

    a_r6_drop_has_no_hard : assert property (@(posedge clk) disable iff (rst)
        notify_valid && notify_act == 2'd2 |-> (notify_err & HARD_BITS) == '0);

endmodule

// File: tb/irq_fault_dispatcher_test.sv
module irq_fault_dispatcher_test;

    localparam int NC = 13;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          irq_in = 1'b0;
    logic [15:0]   holdoff_cyc = 16'd4;
    logic          req_valid, req_write;
    logic [CW-1:0] req_card;
    logic [4:0]    req_reg;
    logic [15:0]   req_wdata;
    logic          rsp_valid = 1'b0;
    logic          rsp_ack = 1'b0;
    logic [15:0]   rsp_rdata = '0;
    logic [NC-1:0] power_off, readout_en;
    logic          notify_valid;
    logic [CW-1:0] notify_card;
    logic [15:0]   notify_err;
    logic [1:0]    notify_act;

    irq_fault_dispatcher #(.NCARD(NC), .HOLD_W(16)) uut (
        .clk(clk), .rst(rst), .irq_in(irq_in), .holdoff_cyc(holdoff_cyc),
        .req_valid(req_valid), .req_write(req_write), .req_card(req_card),
        .req_reg(req_reg), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata),
        .power_off(power_off), .readout_en(readout_en),
        .notify_valid(notify_valid), .notify_card(notify_card),
        .notify_err(notify_err), .notify_act(notify_act)
    );

    always #4 clk = ~clk;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [15:0] err_w [NC];
    logic        ack_ok [NC];
    int lat = 0, cyc = 0;
    int rd_count = 0, wr_count = 0, n_cnt = 0;
    logic [NC-1:0] rd_seen = '0;
    int wr_card = 0, wr_data = 0, wr_reg = 0;
    int n_card = 0, n_err = 0, n_act = 0;
    int last12 = 0, gap_last = 0, c0_starts = 0;
    logic prev_req = 1'b0;
    int bad_req = 0;

    initial begin
        for (int i = 0; i < NC; i++) begin
            err_w[i]  = '0;
            ack_ok[i] = 1'b1;
        end
    end

    // Card responder and monitors, all at the falling edge
    always @(negedge clk) begin
        cyc++;
        if (req_valid && !prev_req && !req_write && req_card == 0) begin
            c0_starts++;
            gap_last = cyc - last12;
        end
        if (req_valid && !req_write && req_reg != 5'h11) bad_req++;
        prev_req = req_valid;
        if (notify_valid) begin
            n_cnt++;
            n_card = int'(notify_card);
            n_err  = int'(notify_err);
            n_act  = int'(notify_act);
        end
        if (rst) begin
            rsp_valid = 1'b0;
            lat = 0;
        end else if (rsp_valid) begin
            rsp_valid = 1'b0;
            lat = 0;
        end else if (req_valid) begin
            if (lat == 2) begin
                rsp_valid = 1'b1;
                rsp_ack   = ack_ok[req_card];
                rsp_rdata = req_write ? 16'h0 : err_w[req_card];
                if (!req_write) begin
                    rd_count++;
                    rd_seen[req_card] = 1'b1;
                    if (req_card == 4'(NC - 1)) last12 = cyc;
                end else begin
                    wr_count++;
                    wr_card = int'(req_card);
                    wr_data = int'(req_wdata);
                    wr_reg  = int'(req_reg);
                end
                lat = 0;
            end else begin
                lat++;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_logs();
        rd_count = 0;
        wr_count = 0;
        rd_seen  = '0;
        n_cnt    = 0;
    endtask

    task automatic run_scan();
        clear_logs();
        @(negedge clk);
        irq_in = 1'b1;
        repeat (3) @(negedge clk);
        irq_in = 1'b0;
        repeat (250) @(negedge clk);
    endtask

    task automatic t_reset_idle();
        @(negedge clk);
        chk("R1 power_off", int'(power_off), 0);
        chk("R1 readout_en", int'(readout_en), 13'h1FFF);
        chk("R1 req_valid", int'(req_valid), 0);
        chk("R1 notify_valid", int'(notify_valid), 0);
        clear_logs();
        repeat (50) @(negedge clk);
        chk("R1 no reads without irq", rd_count, 0);
    endtask

    task automatic t_soft();
        err_w[3] = 16'h0005;
        run_scan();
        chk("R2 all cards read", rd_count, NC);
        chk("R2 read register", bad_req, 0);
        chk("R5 notify count", n_cnt, 1);
        chk("R9 notify card", n_card, 3);
        chk("R9 notify err", n_err, 16'h0005);
        chk("R5 action drop", n_act, 2);
        chk("R5 readout_en", int'(readout_en), 13'h1FF7);
        chk("R5 power_off untouched", int'(power_off), 0);
        chk("R5 one mask write", wr_count, 1);
        chk("R5 write card", wr_card, 3);
        chk("R5 write reg", wr_reg, 5'h12);
        chk("R5 write data", wr_data, 16'h0005);
        err_w[3] = '0;
    endtask

    task automatic t_hard();
        err_w[7] = 16'h0010;
        run_scan();
        chk("R4 notify count", n_cnt, 1);
        chk("R4 card", n_card, 7);
        chk("R4 action off", n_act, 1);
        chk("R4 err", n_err, 16'h0010);
        chk("R4 power_off bit", int'(power_off), 13'h0080);
        chk("R4 no write", wr_count, 0);
        err_w[7] = '0;
    endtask

    task automatic t_both();
        err_w[9] = 16'h0041;
        run_scan();
        chk("R3 card 7 skipped", int'(rd_seen[7]), 0);
        chk("R6 action off", n_act, 1);
        chk("R6 card", n_card, 9);
        chk("R6 power_off", int'(power_off), 13'h0280);
        chk("R6 readout_en keeps bit", int'(readout_en[9]), 1);
        chk("R6 no write", wr_count, 0);
        err_w[9] = '0;
    endtask

    task automatic t_noack();
        err_w[11]  = 16'h0001;
        ack_ok[11] = 1'b0;
        run_scan();
        chk("R7 notify count", n_cnt, 1);
        chk("R7 card", n_card, 11);
        chk("R7 action off", n_act, 1);
        chk("R7 err zero", n_err, 0);
        chk("R7 power_off", int'(power_off[11]), 1);
        chk("R7 no write", wr_count, 0);
        err_w[11]  = '0;
        ack_ok[11] = 1'b1;
    endtask

    task automatic t_ignored();
        err_w[0] = 16'hFF00;
        run_scan();
        chk("R8 no notify", n_cnt, 0);
        chk("R8 no write", wr_count, 0);
        chk("R8 readout_en", int'(readout_en[0]), 1);
        chk("R8 power_off", int'(power_off[0]), 0);
        err_w[0] = '0;
    endtask

    task automatic t_skip_last();
        err_w[12] = 16'h0008;
        run_scan();
        chk("R3 reads skip off cards", rd_count, NC - 3);
        chk("R3 card 9 not read", int'(rd_seen[9]), 0);
        chk("R3 card 11 not read", int'(rd_seen[11]), 0);
        chk("R5 last card drop", n_act, 2);
        chk("R5 last card id", n_card, 12);
        chk("R5 last card write", wr_card, 12);
        chk("R11 power_off kept", int'(power_off), 13'h0A80);
        err_w[12] = '0;
    endtask

    task automatic t_holdoff();
        int start0;
        clear_logs();
        holdoff_cyc = 16'd20;
        start0 = c0_starts;
        @(negedge clk);
        irq_in = 1'b1;
        for (int k = 0; k < 2000 && c0_starts < start0 + 2; k++) @(negedge clk);
        irq_in = 1'b0;
        chk("R10 rescan while irq high", c0_starts - start0, 2);
        chk("R10 gap cycles", gap_last, 20 + 3);
        repeat (300) @(negedge clk);
        chk("R10 idle after irq low", c0_starts - start0, 2);
        chk("R8 quiet cards no notify", n_cnt, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_idle();
        t_soft();
        t_hard();
        t_both();
        t_noack();
        t_ignored();
        t_skip_last();
        t_holdoff();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule